// File: doc/BRIEF.md
# Load Element Width and Saturation Formatter

This block takes the raw data returned by memory for one vector element and turns it into the value written to a destination element. The data is first cut to the access width of the load, which is 8, 16, 32 or 64 bits. Its bytes are then reversed when the instruction variant and the processor byte order call for it. Last, the value is either resized plainly or saturated to the destination element width. The destination width is 8, 16 or 32 bits, or the full 64-bit lane when no override applies.

The result is returned in the low bits of a 64-bit lane, and every bit above the destination width is zero. The output is registered, so it appears one clock after the request with a valid flag. A load pipeline uses the block between the data return and the register file write port. Register placement and the memory access itself are handled elsewhere.

Width codes used on all width inputs: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits.

Top module: `ld_elem_formatter`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `out_data` are cleared to 0 at that edge.
- R2: `out_valid` equals `in_valid` from the previous clock. `out_data` changes only in the cycle after a cycle with `in_valid` high, and otherwise holds its value.
- R3: The accessed bytes are reversed when `in_rev_variant` XNOR `in_little_end` is 1. The reversal covers only the bytes of the access width: byte k becomes byte (n-1-k), where n is the access width in bytes.
- R4: Bits of `in_data` at or above the access width have no effect on the result.
- R5: With `in_sat` = 0, the value is zero-extended from the access width, then truncated to the destination width.
- R6: With `in_sat` = 1 and `in_sat_signed` = 1, the value is read as signed at the access width and clamped to [-2^(w-1), 2^(w-1)-1], where w is the destination width. The result is stored as a w-bit two's complement value.
- R7: With `in_sat` = 1 and `in_sat_signed` = 0, the value is read as unsigned at the access width and clamped to [0, 2^w-1].
- R8: When the destination width is at least the access width, saturation leaves the value unchanged. Signed mode sign-extends it to w bits and unsigned mode zero-extends it.
- R9: Every result bit at or above the destination width is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| in_data | input | 64 | Raw memory data, low-aligned |
| in_acc_wid | input | 2 | Access width code |
| in_rev_variant | input | 1 | Instruction is the byte-reversed variant |
| in_little_end | input | 1 | Processor runs little-endian |
| in_dst_wid | input | 2 | Destination element width code |
| in_sat | input | 1 | Saturation enable |
| in_sat_signed | input | 1 | 1 = signed saturation, 0 = unsigned |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_data | output | 64 | Formatted element, zero-filled above destination width |

## Verification
Byte reversal and saturation act in the same cycle. The clamp must see the reversed value, not the raw one. The bench provokes this with byte-reversed 16-bit loads whose swapped top byte sets the sign bit. One example is raw 0x0080, which becomes 0x8000 and must clamp to 0x80 for an 8-bit signed destination. It also runs long stretches of random requests that mix every width, order flag and saturation mode. Each cycle's output is judged against a behavioural byte-by-byte model kept in the bench.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;

    localparam int unsigned LANE_W     = 64;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned LANE_BYTES = LANE_W / BYTE_W;
    localparam int unsigned NUM_WIDS   = 4;

    typedef enum logic [1:0] {
        WID_8  = 2'd0,
        WID_16 = 2'd1,
        WID_32 = 2'd2,
        WID_64 = 2'd3
    } wid_e;

    typedef logic [LANE_W-1:0] lane_t;

    typedef struct packed {
        lane_t val;
        wid_e  acc;
        wid_e  dst;
        logic  sat;
        logic  sgn;
    } fmt_req_t;

    function automatic lane_t wid_mask(wid_e w);
        case (w)
            WID_8:   return lane_t'(64'h0000_0000_0000_00FF);
            WID_16:  return lane_t'(64'h0000_0000_0000_FFFF);
            WID_32:  return lane_t'(64'h0000_0000_FFFF_FFFF);
            default: return '1;
        endcase
    endfunction

    function automatic logic sign_at(lane_t v, wid_e w);
        case (w)
            WID_8:   return v[7];
            WID_16:  return v[15];
            WID_32:  return v[31];
            default: return v[LANE_W-1];
        endcase
    endfunction

endpackage

// File: rtl/ldfmt_byteswap.sv
module ldfmt_byteswap
    import ldfmt_pkg::*;
(
    input  lane_t din,
    input  wid_e  acc,
    input  logic  swap,
    output lane_t dout
);
    lane_t rev [NUM_WIDS];

    for (genvar g = 0; g < NUM_WIDS; g++) begin : g_rev
        localparam int unsigned NB = 1 << g;
        always_comb begin
            rev[g] = '0;
            for (int k = 0; k < NB; k++) begin
                rev[g][k*BYTE_W +: BYTE_W] = din[(NB-1-k)*BYTE_W +: BYTE_W];
            end
        end
    end

    always_comb begin
        if (swap) dout = rev[acc];
        else      dout = din;
    end
endmodule

// File: rtl/ldfmt_resize.sv
module ldfmt_resize
    import ldfmt_pkg::*;
(
    input  fmt_req_t req,
    output lane_t    dout
);
    lane_t acc_m, dst_m, sx, hi, lo, res;

    always_comb begin
        acc_m = wid_mask(req.acc);
        dst_m = wid_mask(req.dst);
        sx    = req.val;
        if (req.sgn && sign_at(req.val, req.acc)) sx = req.val | ~acc_m;
        hi = dst_m >> 1;
        lo = ~hi;
        if (!req.sat) begin
            res = req.val;
        end else if (req.sgn) begin
            if ($signed(sx) > $signed(hi))      res = hi;
            else if ($signed(sx) < $signed(lo)) res = lo;
            else                                res = sx;
        end else begin
            res = (req.val > dst_m) ? dst_m : req.val;
        end
        dout = res & dst_m;
    end
endmodule

// File: rtl/ld_elem_formatter.sv
module ld_elem_formatter
    import ldfmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [63:0] in_data,
    input  logic [1:0]  in_acc_wid,
    input  logic        in_rev_variant,
    input  logic        in_little_end,
    input  logic [1:0]  in_dst_wid,
    input  logic        in_sat,
    input  logic        in_sat_signed,
    output logic        out_valid,
    output logic [63:0] out_data
);
    wid_e     acc_w;
    lane_t    cut, swapped, formatted;
    logic     do_swap;
    fmt_req_t req;

    assign acc_w   = wid_e'(in_acc_wid);
    assign cut     = in_data & wid_mask(acc_w);
    assign do_swap = ~(in_rev_variant ^ in_little_end);

    ldfmt_byteswap u_swap (
        .din  (cut),
        .acc  (acc_w),
        .swap (do_swap),
        .dout (swapped)
    );

    always_comb begin
        req.val = swapped;
        req.acc = acc_w;
        req.dst = wid_e'(in_dst_wid);
        req.sat = in_sat;
        req.sgn = in_sat_signed;
    end

    ldfmt_resize u_resize (
        .req  (req),
        .dout (formatted)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= formatted;
        end
    end
endmodule

// File: rtl/ld_elem_formatter_chk.sv
module ld_elem_formatter_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [63:0] in_data,
    input logic [1:0]  in_acc_wid,
    input logic        in_rev_variant,
    input logic        in_little_end,
    input logic [1:0]  in_dst_wid,
    input logic        in_sat,
    input logic        in_sat_signed,
    input logic        out_valid,
    input logic [63:0] out_data
);
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_drop_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));
    p_swap16_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_sat && in_acc_wid == 2'd1 && in_dst_wid == 2'd3
         && in_rev_variant == in_little_end)
        |=> out_data == {48'b0, $past(in_data[7:0]), $past(in_data[15:8])});
    p_usat_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sat && !in_sat_signed && in_acc_wid == 2'd1
         && in_dst_wid == 2'd0 && in_rev_variant != in_little_end
         && in_data[15:8] != 8'h00)
        |=> out_data == 64'hFF);
    p_zero_fill8_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_dst_wid == 2'd0) |=> out_data[63:8] == '0);
    p_zero_fill16_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_dst_wid == 2'd1) |=> out_data[63:16] == '0);
    p_zero_fill32_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_dst_wid == 2'd2) |=> out_data[63:32] == '0);
endmodule

bind ld_elem_formatter ld_elem_formatter_chk u_chk (.*);

// File: tb/ld_elem_formatter_test.sv
`timescale 1ns/1ps
module ld_elem_formatter_test;
    logic        clk = 0;
    logic        rst;
    logic        in_valid;
    logic [63:0] in_data;
    logic [1:0]  in_acc_wid;
    logic        in_rev_variant;
    logic        in_little_end;
    logic [1:0]  in_dst_wid;
    logic        in_sat;
    logic        in_sat_signed;
    logic        out_valid;
    logic [63:0] out_data;

    int checks = 0;
    int fails  = 0;
    logic        exp_valid;
    logic [63:0] exp_data;
    string       exp_tag;

    always #4 clk = ~clk;

    ld_elem_formatter uut (.*);

    function automatic logic [63:0] model(logic [63:0] d, int aw, logic rv, logic le,
                                          int dw, logic sat, logic sgn);
        int nb = 1 << aw;
        int ab = 8 * nb;
        int db = 8 << dw;
        logic [63:0] v = 0;
        logic [63:0] dmask;
        longint sv, hi, lo;
        for (int k = 0; k < nb; k++) begin
            if (rv == le) v[8*k +: 8] = d[8*(nb-1-k) +: 8];
            else          v[8*k +: 8] = d[8*k +: 8];
        end
        dmask = (db == 64) ? '1 : ((64'd1 << db) - 1);
        if (!sat) return v & dmask;
        if (sgn) begin
            sv = longint'(v);
            if (ab < 64 && v[ab-1]) sv = sv - longint'(64'd1 << ab);
            hi = (db == 64) ? 64'sh7FFF_FFFF_FFFF_FFFF : ((longint'(1) <<< (db-1)) - 1);
            lo = -hi - 1;
            if (sv > hi) sv = hi;
            if (sv < lo) sv = lo;
            return 64'(sv) & dmask;
        end
        return (v > dmask) ? dmask : v;
    endfunction

    function automatic string tag_of(logic sat, logic sgn);
        if (!sat) return "R5";
        return sgn ? "R6" : "R7";
    endfunction

    task automatic drive(logic v, logic [63:0] d, int aw, logic rv, logic le,
                         int dw, logic sat, logic sgn);
        in_valid = v; in_data = d; in_acc_wid = 2'(aw); in_rev_variant = rv;
        in_little_end = le; in_dst_wid = 2'(dw); in_sat = sat; in_sat_signed = sgn;
        exp_valid = v;
        if (v) begin
            exp_data = model(d, aw, rv, le, dw, sat, sgn);
            exp_tag  = tag_of(sat, sgn);
        end else begin
            exp_tag = "R2";
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== exp_valid || out_data !== exp_data) begin
            fails++;
            $display("FAIL %s: got valid=%0b data=%h, expected valid=%0b data=%h",
                     exp_tag, out_valid, out_data, exp_valid, exp_data);
        end
    endtask

    task automatic want(logic [63:0] e, string tag);
        checks++;
        if (out_data !== e) begin
            fails++;
            $display("FAIL %s: got %h, expected %h", tag, out_data, e);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1;
        drive(1, 64'h1234, 3, 0, 1, 3, 0, 0);
        exp_valid = 0; exp_data = 0; exp_tag = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_data !== 64'h0) begin
            fails++;
            $display("FAIL R1: got valid=%0b data=%h, expected valid=0 data=0", out_valid, out_data);
        end
        rst = 0;
        drive(0, 0, 0, 0, 1, 0, 0, 0); tick();

        // R3 swap decision: rev XNOR le
        drive(1, 64'h1122_3344, 2, 0, 1, 3, 0, 0); tick(); want(64'h1122_3344, "R3");
        drive(1, 64'h1122_3344, 2, 0, 0, 3, 0, 0); tick(); want(64'h4433_2211, "R3");
        drive(1, 64'h1122_3344, 2, 1, 1, 3, 0, 0); tick(); want(64'h4433_2211, "R3");
        drive(1, 64'h1122_3344, 2, 1, 0, 3, 0, 0); tick(); want(64'h1122_3344, "R3");
        drive(1, 64'h0102_0304_0506_0708, 3, 1, 1, 3, 0, 0); tick();
        want(64'h0807_0605_0403_0201, "R3");
        // R4 upper bits ignored
        drive(1, 64'hDEAD_BEEF_0000_1234, 1, 0, 1, 3, 0, 0); tick(); want(64'h1234, "R4");
        drive(1, 64'hDEAD_BEEF_0000_1234, 1, 0, 0, 3, 0, 0); tick(); want(64'h3412, "R4");
        // R5 truncation
        drive(1, 64'h89AB_CDEF, 2, 0, 1, 1, 0, 0); tick(); want(64'hCDEF, "R5");
        // R6 signed clamp
        drive(1, 64'h8000, 1, 0, 1, 0, 1, 1); tick(); want(64'h80, "R6");
        drive(1, 64'h7FFF, 1, 0, 1, 0, 1, 1); tick(); want(64'h7F, "R6");
        drive(1, 64'h0042, 1, 0, 1, 0, 1, 1); tick(); want(64'h42, "R6");
        drive(1, 64'hFFF0, 1, 0, 1, 0, 1, 1); tick(); want(64'hF0, "R6");
        // swap and clamp in the same cycle
        drive(1, 64'h0080, 1, 0, 0, 0, 1, 1); tick(); want(64'h80, "R6");
        // R7 unsigned clamp
        drive(1, 64'h0100, 1, 0, 1, 0, 1, 0); tick(); want(64'hFF, "R7");
        drive(1, 64'h00FE, 1, 0, 1, 0, 1, 0); tick(); want(64'hFE, "R7");
        drive(1, 64'h8000_0000, 2, 0, 1, 1, 1, 0); tick(); want(64'hFFFF, "R7");
        // R8 widening under saturation, R9 zero fill
        drive(1, 64'h80, 0, 0, 1, 2, 1, 1); tick(); want(64'hFFFF_FF80, "R8");
        drive(1, 64'h80, 0, 0, 1, 3, 1, 1); tick(); want(64'hFFFF_FFFF_FFFF_FF80, "R8");
        drive(1, 64'h80, 0, 0, 1, 2, 1, 0); tick(); want(64'h80, "R8");
        drive(1, '1, 3, 0, 1, 0, 0, 0); tick(); want(64'hFF, "R9");
        // R2 hold while idle
        drive(0, 64'h5555, 0, 0, 1, 3, 0, 0); tick(); want(64'hFF, "R2");
        drive(0, 64'hAAAA, 1, 1, 1, 3, 1, 1); tick(); want(64'hFF, "R2");

        for (int i = 0; i < 4000; i++) begin
            logic [63:0] d;
            d = {$urandom(), $urandom()};
            if (i % 3 == 0) d = d >> ($urandom_range(0, 63));
            drive(($urandom_range(0, 3) != 0), d, $urandom_range(0, 3),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  $urandom_range(0, 3), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            tick();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule